// File: doc/BRIEF.md
# Extended Parallel-Port Control Register with Byte FIFO

This block holds the extended control register of a parallel port together with the byte FIFO behind it and the logic that raises service requests. The host reads and writes the register through a one-cycle register strobe. Port-side logic pushes and pops bytes, and a direction input says whether bytes flow from host to peripheral or back. The block reports the selected port mode to the rest of the port. It does not run the handshakes of any mode.

The service bit is armed when the host writes it to 0. When DMA is off, hardware sets the bit back to 1 once the FIFO has reached a level that depends on the direction. When DMA is on, the DMA request is held while the bit is 0, and a terminal-count pulse sets the bit and drops the request. A separate enable turns a falling edge on the active-low error input into an interrupt. Both sources feed one interrupt line, and each stays pending until the host writes the register.

Top module: `ecp_fifo_ctrl`

## Requirements
- R1: After reset the register reads 8'h05: mode 000, error enable 0, DMA enable 0, service bit 1, full 0, empty 1. The interrupt and the DMA request are 0.
- R2: A register write stores bits 7:5 as the mode code. Every code from 000 to 111 reads back unchanged and appears on `port_mode`. Code 011 is the extended mode, code 111 is configuration.
- R3: Register writes to bits 1:0 have no effect. Those bits always read as {full, empty}.
- R4: The FIFO holds 16 bytes and returns them in order. Full is 1 only with 16 bytes stored, and empty is 1 only with none. A push while full and a pop while empty are ignored.
- R5: With DMA disabled (bit 3 = 0), forward direction (`dir_rev` = 0) and the service bit written to 0, the service bit returns to 1 on the clock edge that follows any cycle in which at least 8 FIFO bytes are free.
- R6: With DMA disabled, reverse direction (`dir_rev` = 1) and the service bit written to 0, the service bit returns to 1 on the clock edge that follows any cycle in which at least 8 bytes are stored.
- R7: `dma_req` is 1 exactly while DMA is enabled (bit 3 = 1) and the service bit is 0. In that state the FIFO level does not set the service bit. A `tc` pulse sets the service bit and drops `dma_req` on the same edge.
- R8: With bit 4 = 1, a falling edge on `err_n` raises one interrupt event after a two-flop synchronizer. The event appears on `irq` within 4 cycles. A level held low gives no further event, and a rising edge or a falling edge with bit 4 = 0 gives none.
- R9: `irq` is the OR of the pending error event and the pending service event. Each event stays set until the next register write clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Current register value |
| push | input | 1 | Push one byte into the FIFO |
| push_data | input | 8 | Byte to push |
| pop | input | 1 | Pop the head byte |
| pop_data | output | 8 | Head byte of the FIFO (show-ahead) |
| dir_rev | input | 1 | 0 = forward (host to peripheral), 1 = reverse |
| err_n | input | 1 | Active-low error input from the port, asynchronous |
| tc | input | 1 | DMA terminal count pulse |
| irq | output | 1 | Interrupt, OR of the pending events |
| dma_req | output | 1 | DMA request |
| fifo_full | output | 1 | FIFO holds 16 bytes |
| fifo_empty | output | 1 | FIFO holds no bytes |
| port_mode | output | 3 | Selected port mode code |

## Verification
The bench sweeps every FIFO level from 0 to 16 in both directions, arms the service bit at each level and compares the result against the threshold computed from the level. An off-by-one compare, or a swap of free and stored counts, shows up as a wrong service bit at level 8 or 9. It also fills the FIFO past 16 and drains it past empty. A design that accepted those accesses would corrupt the pointers and return the wrong byte on the push and pop that follow. For the error input it holds the line low after an acknowledged edge and checks that `irq` stays low. A level-sensitive detector would re-raise the interrupt there. It also checks that `tc` drops the DMA request on the very edge at which the service bit sets.

// File: rtl/ecp_pkg.sv
// Package ecp_pkg: shared types and field positions for the extended
// control register. Assumes an 8-bit register with the mode field in 7:5.
package ecp_pkg;

    typedef enum logic [2:0] {
        MODE_STD   = 3'b000,
        MODE_BIDIR = 3'b001,
        MODE_FIFO  = 3'b010,
        MODE_EXT   = 3'b011,
        MODE_EPP   = 3'b100,
        MODE_RSVD  = 3'b101,
        MODE_TEST  = 3'b110,
        MODE_CFG   = 3'b111
    } port_mode_t;

    typedef struct packed {
        port_mode_t mode;
        logic       err_ie;
        logic       dma_en;
        logic       svc;
    } ctl_t;

    localparam int MODE_HI = 7;
    localparam int MODE_LO = 5;
    localparam int ERR_IE_BIT = 4;
    localparam int DMA_EN_BIT = 3;
    localparam int SVC_BIT = 2;

    localparam ctl_t CTL_RESET = '{mode: MODE_STD, err_ie: 1'b0, dma_en: 1'b0, svc: 1'b1};

endpackage

// File: rtl/ecp_byte_fifo.sv
// Module ecp_byte_fifo: synchronous byte FIFO with show-ahead read data
// and an occupancy count. Assumes DEPTH >= 2. A push when full and a pop
// when empty are dropped. When both arrive while full, only the pop is taken.
module ecp_byte_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] pop_data,
    output logic [CW-1:0]    count,
    output logic             full,
    output logic             empty
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic             do_push;
    logic             do_pop;

    // Qualify requests against the current occupancy.
    always_comb begin
        full    = (count == CW'(DEPTH));
        empty   = (count == '0);
        do_push = push && !full;
        do_pop  = pop && !empty;
    end

    // Store accepted bytes.
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    // Advance pointers with wrap at DEPTH and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            if (do_push && !do_pop) begin
                count <= count + 1'b1;
            end else if (do_pop && !do_push) begin
                count <= count - 1'b1;
            end
        end
    end

    // Present the head byte.
    assign pop_data = mem[rd_ptr];

endmodule

// File: rtl/ecp_err_edge.sv
// Module ecp_err_edge: synchronizes the active-low error input and emits a
// one-cycle pulse per falling edge. Assumes the line idles high, so the
// synchronizer resets to ones and no edge is seen after reset.
module ecp_err_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic err_n,
    output logic err_fall
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    // Shift the raw input through the synchronizer chain.
    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= err_n;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], err_n};
            end
        end
    endgenerate

    // Remember the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b1;
        else        last_q <= sync_q[SYNC_STAGES-1];
    end

    assign err_fall = last_q && !sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/ecp_svc_ctl.sv
// Module ecp_svc_ctl: holds the writable control fields, runs the service
// bit and keeps the pending interrupt events. Assumes a register write wins
// over a same-cycle service event on the service bit, while a new event
// wins over the clear that the write applies to the pending flags.
module ecp_svc_ctl
    import ecp_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int WR_THRESH = 8,
    parameter int RD_THRESH = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [7:0]    reg_wdata,
    input  logic [CW-1:0] count,
    input  logic          dir_rev,
    input  logic          tc,
    input  logic          err_fall,
    output ctl_t          ctl,
    output logic          irq,
    output logic          dma_req
);

    logic [CW-1:0] free_cnt;
    logic          lvl_hit;
    logic          svc_event;
    logic          err_event;
    logic          svc_pend;
    logic          err_pend;

    // Decide whether an armed service condition is present this cycle.
    always_comb begin
        free_cnt  = CW'(DEPTH) - count;
        lvl_hit   = dir_rev ? (count >= CW'(RD_THRESH)) : (free_cnt >= CW'(WR_THRESH));
        svc_event = !ctl.svc && !reg_wr && (ctl.dma_en ? tc : lvl_hit);
        err_event = ctl.err_ie && err_fall;
    end

    // Update the control fields from writes and the service bit from events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl <= CTL_RESET;
        end else if (reg_wr) begin
            ctl.mode   <= port_mode_t'(reg_wdata[MODE_HI:MODE_LO]);
            ctl.err_ie <= reg_wdata[ERR_IE_BIT];
            ctl.dma_en <= reg_wdata[DMA_EN_BIT];
            ctl.svc    <= reg_wdata[SVC_BIT];
        end else if (svc_event) begin
            ctl.svc <= 1'b1;
        end
    end

    // Hold pending events until the host writes the register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            svc_pend <= 1'b0;
            err_pend <= 1'b0;
        end else begin
            svc_pend <= (svc_pend && !reg_wr) || svc_event;
            err_pend <= (err_pend && !reg_wr) || err_event;
        end
    end

    assign irq     = svc_pend || err_pend;
    assign dma_req = ctl.dma_en && !ctl.svc;

endmodule

// File: rtl/ecp_fifo_ctrl.sv
// Module ecp_fifo_ctrl: top of the extended control register block. It ties
// the FIFO, the error edge detector and the service logic together and
// assembles the readable register. Assumes the register bus presents one
// write strobe per access and reads combinationally.
module ecp_fifo_ctrl
    import ecp_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int WR_THRESH   = 8,
    parameter int RD_THRESH   = 8,
    parameter int SYNC_STAGES = 2,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       push,
    input  logic [7:0] push_data,
    input  logic       pop,
    output logic [7:0] pop_data,
    input  logic       dir_rev,
    input  logic       err_n,
    input  logic       tc,
    output logic       irq,
    output logic       dma_req,
    output logic       fifo_full,
    output logic       fifo_empty,
    output logic [2:0] port_mode
);

    logic [CW-1:0] count;
    logic          err_fall;
    ctl_t          ctl;

    ecp_byte_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (push_data),
        .pop       (pop),
        .pop_data  (pop_data),
        .count     (count),
        .full      (fifo_full),
        .empty     (fifo_empty)
    );

    ecp_err_edge #(.SYNC_STAGES(SYNC_STAGES)) u_err (
        .clk      (clk),
        .rst_n    (rst_n),
        .err_n    (err_n),
        .err_fall (err_fall)
    );

    ecp_svc_ctl #(.DEPTH(DEPTH), .WR_THRESH(WR_THRESH), .RD_THRESH(RD_THRESH)) u_svc (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .count     (count),
        .dir_rev   (dir_rev),
        .tc        (tc),
        .err_fall  (err_fall),
        .ctl       (ctl),
        .irq       (irq),
        .dma_req   (dma_req)
    );

    // Assemble the readable register from control fields and FIFO status.
    always_comb begin
        reg_rdata = {ctl.mode, ctl.err_ie, ctl.dma_en, ctl.svc, fifo_full, fifo_empty};
        port_mode = ctl.mode;
    end

endmodule

// Module ecp_fifo_ctrl_chk: temporal checks on the top-level ports.
module ecp_fifo_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic [7:0] reg_rdata,
    input logic       push,
    input logic       pop,
    input logic       tc,
    input logic       irq,
    input logic       dma_req,
    input logic       fifo_full,
    input logic       fifo_empty,
    input logic [2:0] port_mode
);

    a_r4_full_empty_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_full && fifo_empty));

    a_r4_full_push_held: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && push && !pop) |=> fifo_full);

    a_r4_empty_pop_held: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_empty && pop && !push) |=> fifo_empty);

    a_r2_mode_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> $stable(port_mode));

    a_r5_svc_no_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr && reg_rdata[2]) |=> reg_rdata[2]);

    a_r7_dma_gated: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> !reg_rdata[2]);

    a_r7_tc_drops_req: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && tc && !reg_wr) |=> (!dma_req && irq));

    a_r9_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !reg_wr) |=> irq);

endmodule

bind ecp_fifo_ctrl ecp_fifo_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_rdata  (reg_rdata),
    .push       (push),
    .pop        (pop),
    .tc         (tc),
    .irq        (irq),
    .dma_req    (dma_req),
    .fifo_full  (fifo_full),
    .fifo_empty (fifo_empty),
    .port_mode  (port_mode)
);

// File: tb/ecp_fifo_ctrl_bench.sv
module ecp_fifo_ctrl_bench;

    localparam int DEPTH = 16;
    localparam int THR   = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       push = 1'b0;
    logic [7:0] push_data = '0;
    logic       pop = 1'b0;
    logic [7:0] pop_data;
    logic       dir_rev = 1'b0;
    logic       err_n = 1'b1;
    logic       tc = 1'b0;
    logic       irq;
    logic       dma_req;
    logic       fifo_full;
    logic       fifo_empty;
    logic [2:0] port_mode;

    int n_vec = 0;
    int n_bad = 0;
    int lvl = 0;
    logic [7:0] mq [DEPTH];
    int mq_rd = 0;
    int mq_wr = 0;
    int seed_byte = 0;

    always #5 clk = ~clk;

    ecp_fifo_ctrl u_ecp_fifo_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .push(push), .push_data(push_data), .pop(pop),
        .pop_data(pop_data), .dir_rev(dir_rev), .err_n(err_n), .tc(tc),
        .irq(irq), .dma_req(dma_req), .fifo_full(fifo_full),
        .fifo_empty(fifo_empty), .port_mode(port_mode)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FIFO_CTL FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] d);
        reg_wr = 1'b1;
        reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    // Push one byte and update the model when it fits.
    task automatic push_b(input logic [7:0] d);
        push = 1'b1;
        push_data = d;
        tick();
        push = 1'b0;
        if (lvl < DEPTH) begin
            mq[mq_wr] = d;
            mq_wr = (mq_wr + 1) % DEPTH;
            lvl++;
        end
    endtask

    // Pop one byte, checking the head against the model when present.
    task automatic pop_b(input bit chk_data);
        if (chk_data && lvl > 0) check("R4 order", pop_data, mq[mq_rd]);
        pop = 1'b1;
        tick();
        pop = 1'b0;
        if (lvl > 0) begin
            mq_rd = (mq_rd + 1) % DEPTH;
            lvl--;
        end
    endtask

    task automatic set_level(input int n);
        while (lvl < n) begin
            push_b(8'(seed_byte));
            seed_byte = seed_byte + 13;
        end
        while (lvl > n) pop_b(1'b0);
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FIFO_CTL FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        check("R1 reg", reg_rdata, 8'h05);
        check("R1 irq", {7'd0, irq}, 8'd0);
        check("R1 dma", {7'd0, dma_req}, 8'd0);
        check("R1 mode", {5'd0, port_mode}, 8'd0);

        // R2 every mode code reads back and drives port_mode
        for (int m = 0; m < 8; m++) begin
            wr({3'(m), 5'b00100});
            check("R2 readback", {5'd0, reg_rdata[7:5]}, 8'(m));
            check("R2 port_mode", {5'd0, port_mode}, 8'(m));
        end

        // R3 low bits ignored on write
        wr(8'b000_0_0_1_10);
        check("R3 status while empty", {6'd0, reg_rdata[1:0]}, 8'h01);

        // R4 fill past full, drain past empty
        for (int i = 0; i < DEPTH + 2; i++) begin
            push_b(8'(i * 7 + 3));
            check("R4 full flag", {7'd0, fifo_full}, {7'd0, (lvl == DEPTH)});
            check("R4 empty flag", {7'd0, fifo_empty}, 8'd0);
        end
        check("R3 status while full", {6'd0, reg_rdata[1:0]}, 8'h02);
        for (int i = 0; i < DEPTH; i++) pop_b(1'b1);
        check("R4 empty after drain", {6'd0, fifo_full, fifo_empty}, 8'h01);
        pop_b(1'b0);
        check("R4 pop on empty ignored", {6'd0, fifo_full, fifo_empty}, 8'h01);
        push_b(8'hA5);
        pop_b(1'b1);
        check("R4 empty again", {7'd0, fifo_empty}, 8'd1);

        // R5 / R6 sweep of every level in both directions
        for (int d = 0; d < 2; d++) begin
            for (int n = 0; n <= DEPTH; n++) begin
                set_level(n);
                dir_rev = d[0];
                wr(8'h00);
                tick(); tick();
                if (d == 0) begin
                    check("R5 fwd svc", {7'd0, reg_rdata[2]}, {7'd0, (DEPTH - n) >= THR});
                    check("R9 fwd irq", {7'd0, irq}, {7'd0, (DEPTH - n) >= THR});
                end else begin
                    check("R6 rev svc", {7'd0, reg_rdata[2]}, {7'd0, n >= THR});
                    check("R9 rev irq", {7'd0, irq}, {7'd0, n >= THR});
                end
                wr(8'h04);
                check("R9 write clears", {7'd0, irq}, 8'd0);
            end
        end

        // R6 dynamic crossing in reverse
        set_level(0);
        dir_rev = 1'b1;
        wr(8'h00);
        for (int i = 0; i < THR - 1; i++) push_b(8'(i));
        tick();
        check("R6 below threshold", {7'd0, reg_rdata[2]}, 8'd0);
        push_b(8'h55);
        tick();
        check("R6 at threshold", {7'd0, reg_rdata[2]}, 8'd1);
        wr(8'h04);

        // R7 DMA gating and terminal count
        set_level(0);
        dir_rev = 1'b0;
        wr(8'h08);
        check("R7 req raised", {7'd0, dma_req}, 8'd1);
        tick(); tick(); tick();
        check("R7 level ignored", {reg_rdata[2], dma_req}, 8'b01);
        tc = 1'b1;
        tick();
        tc = 1'b0;
        check("R7 tc result", {5'd0, reg_rdata[2], dma_req, irq}, 8'b101);
        wr(8'h0C);
        check("R7 req off", {7'd0, dma_req}, 8'd0);

        // R8 / R9 error edge
        wr(8'h14);
        check("R8 idle", {7'd0, irq}, 8'd0);
        err_n = 1'b0;
        tick(); tick(); tick(); tick();
        check("R8 edge raises", {7'd0, irq}, 8'd1);
        tick(); tick();
        check("R9 pending held", {7'd0, irq}, 8'd1);
        wr(8'h14);
        tick(); tick(); tick(); tick(); tick();
        check("R8 one event per edge", {7'd0, irq}, 8'd0);
        err_n = 1'b1;
        tick(); tick(); tick(); tick(); tick();
        check("R8 rising ignored", {7'd0, irq}, 8'd0);
        wr(8'h04);
        err_n = 1'b0;
        tick(); tick(); tick(); tick(); tick();
        check("R8 disabled", {7'd0, irq}, 8'd0);
        err_n = 1'b1;
        tick(); tick(); tick();

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule